// File: doc/BRIEF.md
# Integer Compare Flag Unit

This block is the compare stage of an integer execution pipeline. It receives a first operand and a second operand, subtracts the second from the first at a selectable width of 8, 16 or 32 bits, and drops the difference. Only six status flags survive the subtraction: carry (borrow), signed overflow, sign, zero, auxiliary carry and parity. These flags feed later condition evaluation, such as conditional branches, conditional moves and set-on-condition operations.

The second operand can be a register value, a full-width immediate or a short 8-bit immediate. A short immediate is sign-extended up to the selected width before the subtraction, so a signed byte constant can be compared against a wider operand. A transfer is accepted in any cycle where `inVal` is high. The flags and `outVal` appear one clock edge later. The flags then hold until the next accepted transfer.

Top module: `cmp_flag_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `outVal` and all six flag outputs to 0.
- R2: When `inVal` is high at a rising edge, `outVal` is high after that edge. When `inVal` is low at a rising edge, `outVal` is low after it.
- R3: The six flag outputs keep their values across any rising edge at which `inVal` is low.
- R4: Width encoding on `sizeSel`: 0 selects 8 bits, 1 selects 16 bits, 2 selects 32 bits, and 3 is treated as 32 bits. Operand bits above the selected width have no effect on any flag.
- R5: `flagC` is 1 exactly when the first operand, read as unsigned at the selected width, is less than the (extended) second operand.
- R6: `flagO` is 1 exactly when the signed difference of the two operands at the selected width falls outside the signed range of that width.
- R7: `flagS` equals the top bit of the difference at the selected width. `flagZ` is 1 exactly when every bit of the difference within the selected width is 0.
- R8: `flagA` is 1 exactly when bits 3..0 of the first operand, read as unsigned, are less than bits 3..0 of the second operand, whatever the width.
- R9: `flagP` is 1 exactly when bits 7..0 of the difference hold an even number of ones, whatever the width.
- R10: When `immShort` is 1, only `opB[7:0]` is used, and bit 7 is replicated up to the selected width. `opB[31:8]` then has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| inVal | input | 1 | Operands valid, captured at this edge |
| opA | input | 32 | First operand (minuend) |
| opB | input | 32 | Second operand: register value or immediate |
| sizeSel | input | 2 | Operand width: 0 = 8, 1 = 16, 2 or 3 = 32 bits |
| immShort | input | 1 | 1 = opB is a short immediate in bits 7..0, to be sign-extended |
| outVal | output | 1 | Flags updated by the previous edge |
| flagC | output | 1 | Unsigned borrow |
| flagO | output | 1 | Signed overflow |
| flagS | output | 1 | Sign of the difference |
| flagZ | output | 1 | Difference is zero |
| flagA | output | 1 | Borrow out of bit 3 |
| flagP | output | 1 | Even parity of the low difference byte |

## Verification
The assertions check the timing contract on every cycle: `outVal` follows `inVal` by one edge, the flags stay still without a capture, and reset leaves every flag at 0. They also check one structural fact on every cycle: a zero difference can never come with borrow, overflow, sign, auxiliary carry or odd parity. The actual flag values for given operands can only be shown by the bench's directed scenarios. Those scenarios cover each width, borrow and overflow boundaries, short-immediate sign extension, and the fact that upper operand bits are ignored. Each result is compared against an arithmetic model built from the requirements.

// File: rtl/cmp_flag_pkg.sv
package cmp_flag_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } opSize_e;

  typedef struct packed {
    logic capture;
    logic clear;
  } dpCtrl_t;

  typedef struct packed {
    logic carry;
    logic ovf;
    logic sign;
    logic zero;
    logic aux;
    logic par;
  } flags_t;

endpackage

// File: rtl/cmp_flag_ctrl.sv
module cmp_flag_ctrl
  import cmp_flag_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    inVal,
  output dpCtrl_t ctrl,
  output logic    outVal
);

  always_comb begin
    ctrl.clear   = rst;
    ctrl.capture = inVal & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outVal <= 1'b0;
    else     outVal <= inVal;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    inVal |=> outVal);   // R2
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
    !inVal |=> !outVal);  // R2

endmodule

// File: rtl/cmp_flag_dp.sv
module cmp_flag_dp
  import cmp_flag_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  dpCtrl_t           ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [1:0]        sizeSel,
  input  logic              immShort,
  output flags_t            flagQ
);

  localparam int SHORT_W = 8;
  localparam int NUM_SZ  = $clog2(DATA_W / SHORT_W) + 1;
  localparam int IDX_W   = (NUM_SZ > 1) ? $clog2(NUM_SZ) : 1;

  logic [DATA_W-1:0] bExt;
  logic [NUM_SZ-1:0] cArr, oArr, sArr, zArr;
  logic [IDX_W-1:0]  szIdx;
  logic [4:0]        nibDiff;
  logic [7:0]        lowDiff;
  flags_t            flagD;

  // R10: short immediate keeps bit 7 as the sign up to the full width
  assign bExt = immShort ? {{(DATA_W-SHORT_W){opB[SHORT_W-1]}}, opB[SHORT_W-1:0]} : opB;

  // one subtractor slice per supported width
  for (genvar g = 0; g < NUM_SZ; g++) begin : gSz
    localparam int W = SHORT_W << g;
    logic [W:0] diff;
    assign diff    = {1'b0, opA[W-1:0]} - {1'b0, bExt[W-1:0]};
    assign cArr[g] = diff[W];
    assign sArr[g] = diff[W-1];
    assign zArr[g] = ~|diff[W-1:0];
    assign oArr[g] = (opA[W-1] ^ bExt[W-1]) & (opA[W-1] ^ diff[W-1]);
  end

  always_comb begin
    if (sizeSel > 2'(NUM_SZ - 1)) szIdx = IDX_W'(NUM_SZ - 1);
    else                          szIdx = IDX_W'(sizeSel);
  end

  assign nibDiff = {1'b0, opA[3:0]} - {1'b0, bExt[3:0]};
  assign lowDiff = opA[7:0] - bExt[7:0];

  always_comb begin
    flagD.carry = cArr[szIdx];
    flagD.ovf   = oArr[szIdx];
    flagD.sign  = sArr[szIdx];
    flagD.zero  = zArr[szIdx];
    flagD.aux   = nibDiff[4];
    flagD.par   = ~^lowDiff;
  end

  always_ff @(posedge clk) begin
    if (ctrl.clear)        flagQ <= '0;
    else if (ctrl.capture) flagQ <= flagD;
  end

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (ctrl.clear)
    !ctrl.capture |=> $stable(flagQ));  // R3
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (ctrl.clear)
    $past(ctrl.clear) |-> (flagQ == '0));  // R1
  AST_ZERO_CONSISTENT: assert property (@(posedge clk) disable iff (ctrl.clear)
    flagQ.zero |-> (!flagQ.carry && !flagQ.ovf && !flagQ.sign && !flagQ.aux && flagQ.par));  // R7

endmodule

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit
  import cmp_flag_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inVal,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic [1:0]  sizeSel,
  input  logic        immShort,
  output logic        outVal,
  output logic        flagC,
  output logic        flagO,
  output logic        flagS,
  output logic        flagZ,
  output logic        flagA,
  output logic        flagP
);

  dpCtrl_t ctrl;
  flags_t  flagQ;

  cmp_flag_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .inVal  (inVal),
    .ctrl   (ctrl),
    .outVal (outVal)
  );

  cmp_flag_dp #(.DATA_W(32)) u_dp (
    .clk      (clk),
    .ctrl     (ctrl),
    .opA      (opA),
    .opB      (opB),
    .sizeSel  (sizeSel),
    .immShort (immShort),
    .flagQ    (flagQ)
  );

  assign flagC = flagQ.carry;
  assign flagO = flagQ.ovf;
  assign flagS = flagQ.sign;
  assign flagZ = flagQ.zero;
  assign flagA = flagQ.aux;
  assign flagP = flagQ.par;

endmodule

// File: tb/cmp_flag_unit_test.sv
module cmp_flag_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inVal = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [1:0]  sizeSel = '0;
  logic        immShort = 1'b0;
  logic        outVal, flagC, flagO, flagS, flagZ, flagA, flagP;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  cmp_flag_unit uut (
    .clk(clk), .rst(rst), .inVal(inVal), .opA(opA), .opB(opB),
    .sizeSel(sizeSel), .immShort(immShort), .outVal(outVal),
    .flagC(flagC), .flagO(flagO), .flagS(flagS), .flagZ(flagZ),
    .flagA(flagA), .flagP(flagP)
  );

  function automatic logic [5:0] flagVec();
    return {flagC, flagO, flagS, flagZ, flagA, flagP};
  endfunction

  // expected flags {C,O,S,Z,A,P} from integer arithmetic
  function automatic logic [5:0] model(logic [31:0] a, logic [31:0] b, logic [1:0] sz, logic sh);
    int     w;
    longint ua, ub, full, half, sa, sb, sd, d;
    logic   c, o, s, z, af, p;
    logic [7:0] lo;
    w    = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    full = longint'(1) << w;
    half = full / 2;
    if (sh) b = {{24{b[7]}}, b[7:0]};
    ua = longint'(a) % full;
    ub = longint'(b) % full;
    c  = (ua < ub);
    d  = (ua - ub + full) % full;
    s  = (d >= half);
    z  = (d == 0);
    sa = (ua >= half) ? ua - full : ua;
    sb = (ub >= half) ? ub - full : ub;
    sd = sa - sb;
    o  = (sd >= half) || (sd < -half);
    af = ((ua % 16) < (ub % 16));
    lo = 8'(d % 256);
    p  = ($countones(lo) % 2 == 0);
    return {c, o, s, z, af, p};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [31:0] a, logic [31:0] b, logic [1:0] sz, logic sh);
    @(negedge clk);
    opA = a; opB = b; sizeSel = sz; immShort = sh; inVal = 1'b1;
    @(negedge clk);
    inVal = 1'b0;
  endtask

  task automatic cmpCheck(string req, logic [31:0] a, logic [31:0] b, logic [1:0] sz, logic sh);
    drive(a, b, sz, sh);
    check({req, " outVal"}, 32'(outVal), 32'd1);
    check({req, " flags"}, 32'(flagVec()), 32'(model(a, b, sz, sh)));
  endtask

  task automatic t_reset();
    check("R1 outVal after reset", 32'(outVal), 32'd0);
    check("R1 flags after reset", 32'(flagVec()), 32'd0);
  endtask

  task automatic t_byte();
    cmpCheck("R5 R9 byte borrow", 32'h0000_0000, 32'h0000_0001, 2'd0, 1'b0);
    check("R5 literal 0-1 byte", 32'(flagVec()), 32'b101011);
    cmpCheck("R6 byte overflow", 32'h0000_0080, 32'h0000_0001, 2'd0, 1'b0);
    check("R6 literal 80-01", 32'(flagVec()), 32'b010010);
    cmpCheck("R7 byte equal", 32'h0000_0055, 32'h0000_0055, 2'd0, 1'b0);
    check("R7 literal equal", 32'(flagVec()), 32'b000101);
  endtask

  task automatic t_widths();
    cmpCheck("R4 word", 32'h0000_8000, 32'h0000_0001, 2'd1, 1'b0);
    cmpCheck("R4 dword", 32'h8000_0000, 32'h0000_0001, 2'd2, 1'b0);
    check("R6 literal dword ovf", 32'(flagO), 32'd1);
    cmpCheck("R4 reserved size as dword", 32'h1234_5678, 32'h9234_5679, 2'd3, 1'b0);
    cmpCheck("R5 dword unsigned", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 2'd2, 1'b0);
    check("R5 literal dword carry", 32'(flagC), 32'd1);
  endtask

  task automatic t_upper_ignored();
    cmpCheck("R4 byte upper ignored", 32'hABCD_0012, 32'h1234_0012, 2'd0, 1'b0);
    check("R4 literal zero", 32'(flagZ), 32'd1);
    cmpCheck("R4 word upper ignored", 32'hFFFF_1000, 32'h0000_1000, 2'd1, 1'b0);
    check("R4 literal word zero", 32'(flagZ), 32'd1);
  endtask

  task automatic t_short_imm();
    cmpCheck("R10 short neg vs dword", 32'hFFFF_FFFF, 32'h1234_56FF, 2'd2, 1'b1);
    check("R10 literal equal", 32'(flagZ), 32'd1);
    cmpCheck("R10 short neg vs word", 32'h0000_0001, 32'h0000_0080, 2'd1, 1'b1);
    check("R10 literal borrow", 32'(flagC), 32'd1);
    cmpCheck("R10 short pos vs dword", 32'h0000_007F, 32'hFFFF_FF7F, 2'd2, 1'b1);
    check("R10 literal pos zero", 32'(flagZ), 32'd1);
  endtask

  task automatic t_aux_parity();
    cmpCheck("R8 aux nibble borrow", 32'h0000_0310, 32'h0000_0101, 2'd1, 1'b0);
    check("R8 literal aux", 32'(flagA), 32'd1);
    cmpCheck("R9 parity odd", 32'h0001_0007, 32'h0000_0000, 2'd2, 1'b0);
    check("R9 literal parity", 32'(flagP), 32'd0);
  endtask

  task automatic t_hold_and_valid();
    logic [5:0] held;
    cmpCheck("R2 capture", 32'h0000_0003, 32'h0000_0009, 2'd0, 1'b0);
    held = flagVec();
    opA = 32'h0000_0009; opB = 32'h0000_0009; sizeSel = 2'd0;
    @(negedge clk);
    check("R2 outVal low without inVal", 32'(outVal), 32'd0);
    check("R3 flags held", 32'(flagVec()), 32'(held));
    @(negedge clk);
    check("R3 flags held 2", 32'(flagVec()), 32'(held));
  endtask

  task automatic t_reset_mid();
    cmpCheck("R1 prep", 32'h0000_0000, 32'h0000_0001, 2'd2, 1'b0);
    @(negedge clk);
    rst = 1'b1; inVal = 1'b1;
    @(negedge clk);
    rst = 1'b0; inVal = 1'b0;
    check("R1 outVal cleared", 32'(outVal), 32'd0);
    check("R1 flags cleared", 32'(flagVec()), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_byte();
    t_widths();
    t_upper_ignored();
    t_short_imm();
    t_aux_parity();
    t_hold_and_valid();
    t_reset_mid();
    for (int i = 0; i < 40; i++) begin
      logic [31:0] a, b;
      a = 32'(i * 32'h9E37_79B9 + 32'h1357);
      b = 32'(i * 32'h7F4A_7C15 + 32'h2468);
      cmpCheck("R5 R6 R7 sweep", a, b, 2'(i % 4), 1'(i % 3 == 0));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule